// File: doc/BRIEF.md
# Eight-Lane Serializer Power and Output-Enable Control

This block is the control and framing logic for an eight-lane, ten-to-one serializer. It runs on the serial bit clock. An internal phase counter divides that clock by twelve to form the word period. Once per word period the block captures a 10-bit parallel word for every lane. It wraps each word in a start bit and a stop bit and shifts it out least significant bit first. It drives one serial data bit and one output-enable per lane. A low output-enable stands for a high-impedance driver.

Power is handled at two levels. A global active-low power-down stops the modelled PLL. Lifting it starts a full initialisation that ends when `lock_ready` rises, a fixed number of word periods later. Each lane also has its own active-low power-down. It puts only that lane to sleep and leaves lock intact. A woken lane comes back after a short fixed number of word periods, with no re-initialisation. A global output enable masks all outputs without disturbing any state. A per-lane sync request replaces that lane's data with a fixed sync word, so a receiver's lock-loss line can be wired straight to it.

Top module: `serdes_lane_ctrl`

## Requirements
- R1: While rst_n is low and in the cycle after its release, lock_ready is 0, every ser_oe bit is 0 and every ser_out bit is 0.
- R2: After glb_pd_n goes high, lock_ready rises at the edge of word tick number LOCK_WORDS. Before that edge no ser_oe bit is high.
- R3: word_tick is high for one clock in every twelve while glb_pd_n is high, and stays low while glb_pd_n is low.
- R4: Each lane sends a 12-bit frame LSB first. Bit 0 is a start bit of 1. Bits 1 to 10 carry the word captured at the word_tick edge, its bit 0 first, taken from par_data[10*lane +: 10]. Bit 11 is a stop bit of 0.
- R5: Lanes are independent: each lane sends its own slice of par_data in the same word period.
- R6: Driving lane_pd_n[i] low clears ser_oe[i] from the next clock. The other lanes keep their enables, and lock_ready stays high.
- R7: After lane_pd_n[i] returns high with lock held, ser_oe[i] rises at the edge of the WAKE_WORDS-th following word tick, in step with a frame start bit.
- R8: Driving glb_pd_n low clears lock_ready and every ser_oe bit from the next clock. Raising it again repeats the full LOCK_WORDS initialisation.
- R9: With out_en low, every ser_oe and ser_out bit is 0. Raising out_en restores the previous enable pattern at once, with no re-initialisation.
- R10: With sync_req[i] high, lane i sends the sync word 10'b0000011111 (five ones, then five zeros, LSB first) in place of its data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_pd_n | input | 1 | Global active-low power-down |
| lane_pd_n | input | LANES | Per-lane active-low power-down |
| out_en | input | 1 | Global output enable |
| sync_req | input | LANES | Per-lane sync pattern request |
| par_data | input | LANES*WORD_W | Parallel words, lane i at bits [10*i +: 10] |
| word_tick | output | 1 | High in the bit clock before each word capture |
| lock_ready | output | 1 | Modelled PLL lock |
| ser_out | output | LANES | Serial data per lane |
| ser_oe | output | LANES | Driver enable per lane; 0 means high impedance |

## Verification
The embedded assertions watch the relations that hold in every cycle. Global power-down must clear lock and all enables on the next edge. Lock must persist while power is on. A lane that has just woken must not drive at once. No lane may output a 1 while disabled, and word ticks must never come back to back. Frame contents, the exact lock and wake latencies, sync-word substitution and the restore after output enable can only be shown by the bench scenarios. These scenarios count word ticks and sample whole frames bit by bit.

// File: rtl/serdes_lane_ctrl.sv
module serdes_lane_ctrl #(
  parameter int LANES      = 8,
  parameter int WORD_W     = 10,
  parameter int LOCK_WORDS = 64,
  parameter int WAKE_WORDS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    glb_pd_n,
  input  logic [LANES-1:0]        lane_pd_n,
  input  logic                    out_en,
  input  logic [LANES-1:0]        sync_req,
  input  logic [LANES*WORD_W-1:0] par_data,
  output logic                    word_tick,
  output logic                    lock_ready,
  output logic [LANES-1:0]        ser_out,
  output logic [LANES-1:0]        ser_oe
);

  localparam int FRAME_W = WORD_W + 2;
  localparam int PH_W    = $clog2(FRAME_W);
  localparam int LK_W    = $clog2(LOCK_WORDS + 1);
  localparam int WK_W    = $clog2(WAKE_WORDS + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_W - 1);
  localparam logic [LK_W-1:0] LK_LAST = LK_W'(LOCK_WORDS - 1);
  localparam logic [WK_W-1:0] WK_FULL = WK_W'(WAKE_WORDS);
  localparam logic [WORD_W-1:0] SYNC_WORD =
    WORD_W'((1 << (WORD_W / 2)) - 1);

  logic [PH_W-1:0] phase;
  logic [LK_W-1:0] lock_cnt;
  logic [LANES-1:0] lane_live;

  assign word_tick = glb_pd_n && (phase == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (!glb_pd_n || word_tick) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_cnt   <= '0;
      lock_ready <= 1'b0;
    end else if (!glb_pd_n) begin
      lock_cnt   <= '0;
      lock_ready <= 1'b0;
    end else if (word_tick && !lock_ready) begin
      if (lock_cnt == LK_LAST) lock_ready <= 1'b1;
      else                     lock_cnt   <= lock_cnt + 1'b1;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [WK_W-1:0]    wake_cnt;
    logic [FRAME_W-1:0] shreg;
    logic [WORD_W-1:0]  word;

    assign word = sync_req[i] ? SYNC_WORD : par_data[i*WORD_W +: WORD_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wake_cnt <= '0;
      end else if (!lane_pd_n[i]) begin
        wake_cnt <= '0;
      end else if (!glb_pd_n || !lock_ready) begin
        wake_cnt <= WK_FULL;
      end else if (word_tick && wake_cnt != WK_FULL) begin
        wake_cnt <= wake_cnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shreg <= '0;
      end else if (!glb_pd_n) begin
        shreg <= '0;
      end else if (word_tick) begin
        shreg <= {1'b0, word, 1'b1};
      end else begin
        shreg <= {1'b0, shreg[FRAME_W-1:1]};
      end
    end

    assign lane_live[i] = lock_ready && lane_pd_n[i] && (wake_cnt == WK_FULL);
    assign ser_oe[i]    = out_en && lane_live[i];
    assign ser_out[i]   = ser_oe[i] && shreg[0];

    a_r7_no_instant_wake: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lane_pd_n[i]) && lock_ready) |-> !ser_oe[i]);
  end

  a_r8_pd_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_pd_n |=> (!lock_ready && ser_oe == '0));

  a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_ready && glb_pd_n) |=> lock_ready);

  a_r3_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    word_tick |=> !word_tick);

  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_out & ~ser_oe) == '0);

  a_r2_no_drive_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_ready |-> ser_oe == '0);

endmodule

// File: tb/tb_serdes_lane_ctrl.sv
module tb_serdes_lane_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int WW = 10;
  localparam int LOCKW = 4;
  localparam int WAKEW = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic glb_pd_n = 0;
  logic [LANES-1:0] lane_pd_n = '1;
  logic out_en = 1;
  logic [LANES-1:0] sync_req = '0;
  logic [LANES*WW-1:0] par_data = '0;
  logic word_tick, lock_ready;
  logic [LANES-1:0] ser_out, ser_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  serdes_lane_ctrl #(.LANES(LANES), .WORD_W(WW), .LOCK_WORDS(LOCKW), .WAKE_WORDS(WAKEW)) dut (
    .clk(clk), .rst_n(rst_n), .glb_pd_n(glb_pd_n), .lane_pd_n(lane_pd_n),
    .out_en(out_en), .sync_req(sync_req), .par_data(par_data),
    .word_tick(word_tick), .lock_ready(lock_ready), .ser_out(ser_out), .ser_oe(ser_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic grab_frame(int lane, output logic [11:0] f);
    @(negedge clk);
    while (!word_tick) @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      f[k] = ser_out[lane];
    end
  endtask

  task automatic ticks_until_lock(output int n);
    n = 0;
    @(negedge clk);
    while (!lock_ready && n < 100) begin
      if (word_tick) n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 lock", lock_ready, 0);
    check("R1 oe", ser_oe, 0);
    check("R1 out", ser_out, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 oe after release", ser_oe, 0);
  endtask

  task automatic t_init;
    int n, gap, cnt;
    glb_pd_n = 1;
    ticks_until_lock(n);
    check("R2 lock latency", n, LOCKW);
    check("R2 oe after lock", ser_oe, 8'hFF);
    gap = 0; cnt = 0;
    while (!word_tick) @(negedge clk);
    @(negedge clk);
    while (!word_tick) begin gap++; @(negedge clk); end
    check("R3 tick period", gap + 1, 12);
  endtask

  task automatic t_frames;
    logic [11:0] f0, f3, f7;
    for (int i = 0; i < LANES; i++) par_data[i*WW +: WW] = WW'(10'h2A5 ^ (i * 37));
    grab_frame(3, f3);
    check("R4 frame lane3", f3, {1'b0, 10'h2A5 ^ 10'(3*37), 1'b1});
    grab_frame(0, f0);
    check("R5 frame lane0", f0, {1'b0, 10'h2A5, 1'b1});
    grab_frame(7, f7);
    check("R5 frame lane7", f7, {1'b0, 10'h2A5 ^ 10'(7*37), 1'b1});
  endtask

  task automatic t_sync;
    logic [11:0] f;
    sync_req[5] = 1;
    grab_frame(5, f);
    check("R10 sync frame", f, {1'b0, 10'b0000011111, 1'b1});
    sync_req[5] = 0;
    grab_frame(5, f);
    check("R10 data resumes", f, {1'b0, 10'h2A5 ^ 10'(5*37), 1'b1});
  endtask

  task automatic t_lane_pd;
    int n;
    logic [11:0] f;
    lane_pd_n[2] = 0;
    @(negedge clk);
    check("R6 lane oe", ser_oe, 8'hFB);
    repeat (30) @(negedge clk);
    check("R6 lock kept", lock_ready, 1);
    check("R6 lane out", ser_out[2], 0);
    lane_pd_n[2] = 1;
    n = 0;
    @(negedge clk);
    while (!ser_oe[2] && n < 100) begin
      if (word_tick) n++;
      @(negedge clk);
    end
    check("R7 wake latency", n, WAKEW);
    check("R7 start bit on wake", ser_out[2], 1);
    check("R7 lock kept", lock_ready, 1);
  endtask

  task automatic t_out_en;
    lane_pd_n[6] = 0;
    @(negedge clk);
    out_en = 0;
    @(negedge clk);
    check("R9 oe off", ser_oe, 0);
    repeat (13) begin
      checks++;
      if (ser_out !== 0) begin errors++; $display("FAIL R9: actual %0h expected 0", ser_out); end
      @(negedge clk);
    end
    out_en = 1;
    #1;
    check("R9 restore", ser_oe, 8'hBF);
    lane_pd_n[6] = 1;
  endtask

  task automatic t_global_pd;
    int n;
    glb_pd_n = 0;
    @(negedge clk);
    check("R8 lock dropped", lock_ready, 0);
    check("R8 oe dropped", ser_oe, 0);
    repeat (5) @(negedge clk);
    check("R3 no tick in pd", word_tick, 0);
    glb_pd_n = 1;
    ticks_until_lock(n);
    check("R8 reinit latency", n, LOCKW);
    check("R8 all lanes back", ser_oe, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_init();
    t_frames();
    t_sync();
    t_lane_pd();
    t_out_en();
    t_global_pd();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule